// File: doc/BRIEF.md
# Phase-Frequency Detector with Selectable Polarity

This block compares two single-bit pulse trains, a reference pulse and a divided-oscillator pulse, both produced in the block's clock domain. A rising edge on either input arms a matching flag. The "raise" flag follows the reference and the "lower" flag follows the divided pulse. When both flags are armed together, they clear on the next clock edge, so every phase comparison ends with a one-cycle overlap. This overlap avoids a dead zone around lock. The flags then drive a primary charge-pump command and a secondary charge-pump command, two push-pull comparator outputs, a registered lock indicator and a monitor multiplexer.

A polarity select input reverses the sense of the detector, so the same block can serve an oscillator whose frequency rises or falls with control voltage. The same input also picks which of the two pulse trains appears on the monitor output. An auxiliary enable input lets the secondary pump command copy the primary one or hold it in high impedance. It is used to short a stage of an external loop filter during acquisition. Both control inputs are asynchronous and pass through synchronizers. Each pump command is a source/sink pair plus a drive-enable, and high impedance means the enable is low.

Top module: `pfd_polarity_top`

## Requirements
- R1: The raise flag (`up_o`) sets on the clock edge that samples a 0-to-1 change of `ref_pulse`. The lower flag (`dn_o`) sets on the edge that samples a 0-to-1 change of `div_pulse`. An input held high sets its flag only once.
- R2: When both flags are set, both clear on the next clock edge. Rising edges on both inputs in the same cycle give exactly one cycle with both flags high.
- R3: With the synchronized polarity high and only the raise flag set, the primary pump sources (src=1, snk=0, oe=1) and `ref_cmp_o`=0, `div_cmp_o`=0. With only the lower flag set, it sinks (src=0, snk=1, oe=1) and `ref_cmp_o`=1, `div_cmp_o`=1.
- R4: With the synchronized polarity low, the mapping is reversed. Only the raise flag set gives sink with both comparator outputs 1. Only the lower flag set gives source with both comparator outputs 0.
- R5: With neither flag or both flags set, the primary pump is high impedance (src=snk=oe=0), `div_cmp_o`=1 and `ref_cmp_o`=0. src and snk are never 1 together.
- R6: `lock_o` is the registered NOR of the two flags. It goes low one clock after either flag is set and returns high one clock after both are clear.
- R7: `mon_o` equals `ref_pulse` while the synchronized polarity is high and `div_pulse` while it is low, with no register on the data path.
- R8: While the synchronized auxiliary enable is high, the secondary pump command equals the primary one. While it is low, the secondary command is src=snk=oe=0. The primary command does not depend on the auxiliary enable.
- R9: `pol_async` and `aux_en_async` pass through two flip-flop stages. A change takes effect after the second clock edge that samples it. Both synchronizers reset to 1.
- R10: During reset both flags are 0, `lock_o`=1, both pumps are high impedance, `div_cmp_o`=1 and `ref_cmp_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference pulse train |
| div_pulse | input | 1 | Divided oscillator pulse train |
| pol_async | input | 1 | Polarity select, asynchronous (1 = normal sense) |
| aux_en_async | input | 1 | Secondary pump enable, asynchronous |
| up_o | output | 1 | Raise flag |
| dn_o | output | 1 | Lower flag |
| ref_cmp_o | output | 1 | Push-pull comparator output, rests low |
| div_cmp_o | output | 1 | Push-pull comparator output, rests high |
| pump_src_o | output | 1 | Primary pump source command |
| pump_snk_o | output | 1 | Primary pump sink command |
| pump_oe_o | output | 1 | Primary pump drive enable (0 = high impedance) |
| aux_src_o | output | 1 | Secondary pump source command |
| aux_snk_o | output | 1 | Secondary pump sink command |
| aux_oe_o | output | 1 | Secondary pump drive enable |
| lock_o | output | 1 | Registered lock indicator, low on phase error |
| mon_o | output | 1 | Monitor output, selected pulse train |

## Verification
The detector is tried with the reference leading, the divided pulse leading and both edges arriving in the same cycle. Each of these runs under both polarity settings and both auxiliary-enable settings. Leading patterns separate source from sink and show whether the polarity swap is applied. Coincident edges show the overlap cycle that must leave the pump in high impedance. Varied gaps between the two edges show that the flag holds and that the lock output follows one cycle behind. Directed runs cover an input held high across a comparison, a polarity change while a flag is armed to time the synchronizer, and the monitor multiplexer under each polarity.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic src;
    logic snk;
    logic oe;
  } pump_cmd_t;

  // Push alone sources, pull alone sinks, both or neither float.
  function automatic pump_cmd_t pump_from(input logic push, input logic pull);
    pump_cmd_t c;
    c.src = push & ~pull;
    c.snk = pull & ~push;
    c.oe  = push ^ pull;
    return c;
  endfunction

  function automatic pump_cmd_t pump_gate(input pump_cmd_t c, input logic en);
    pump_cmd_t g;
    g.src = c.src & en;
    g.snk = c.snk & en;
    g.oe  = c.oe & en;
    return g;
  endfunction

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("pfd_sync needs at least two stages");
  end
endmodule

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
  parameter int CHANNELS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic div_in,
  output logic up,
  output logic dn
);
  localparam int REF_CH = 0;
  localparam int DIV_CH = 1;

  logic [CHANNELS-1:0] lvl, prev, rise, armed;
  logic                both_armed;

  assign lvl[REF_CH] = ref_in;
  assign lvl[DIV_CH] = div_in;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~prev[i];
  end

  assign both_armed = &armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      armed <= '0;
    end else begin
      prev  <= lvl;
      armed <= both_armed ? '0 : (armed | rise);
    end
  end

  assign up = armed[REF_CH];
  assign dn = armed[DIV_CH];

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    both_armed |=> (armed == '0));

  assert_set_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[REF_CH] && !both_armed) |=> up);

  assert_set_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[DIV_CH] && !both_armed) |=> dn);

  assert_no_self_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !rise[REF_CH]) |=> !up);
endmodule

// File: rtl/pfd_out.sv
module pfd_out
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic pol_hi,
  input  logic aux_en,
  input  logic ref_in,
  input  logic div_in,
  output logic ref_cmp,
  output logic div_cmp,
  output pump_cmd_t main_cmd,
  output pump_cmd_t aux_cmd,
  output logic lock,
  output logic mon
);
  logic push, pull;
  logic lock_q;

  // Polarity swaps which flag pushes the pump.
  assign push = pol_hi ? up : dn;
  assign pull = pol_hi ? dn : up;

  assign main_cmd = pump_from(push, pull);
  assign aux_cmd  = pump_gate(main_cmd, aux_en);

  assign div_cmp = ~main_cmd.src;
  assign ref_cmp = main_cmd.snk;

  assign mon = pol_hi ? ref_in : div_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= ~(up | dn);
  end
  assign lock = lock_q;

  assert_pump_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_cmd.src && main_cmd.snk));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up == dn) |-> (div_cmp && !ref_cmp && !main_cmd.oe));

  assert_lock_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up || dn) |=> !lock);

  assert_aux_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_en |-> (!aux_cmd.oe && !aux_cmd.src && !aux_cmd.snk));

  assert_aux_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |-> (aux_cmd == main_cmd));
endmodule

// File: rtl/pfd_polarity_top.sv
module pfd_polarity_top
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic div_pulse,
  input  logic pol_async,
  input  logic aux_en_async,
  output logic up_o,
  output logic dn_o,
  output logic ref_cmp_o,
  output logic div_cmp_o,
  output logic pump_src_o,
  output logic pump_snk_o,
  output logic pump_oe_o,
  output logic aux_src_o,
  output logic aux_snk_o,
  output logic aux_oe_o,
  output logic lock_o,
  output logic mon_o
);
  logic      pol_hi, aux_en;
  logic      up, dn;
  pump_cmd_t main_cmd, aux_cmd;

  pfd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pol_sync (
    .clk(clk), .rst_n(rst_n), .d(pol_async), .q(pol_hi));

  pfd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_aux_sync (
    .clk(clk), .rst_n(rst_n), .d(aux_en_async), .q(aux_en));

  pfd_edge_core #(.CHANNELS(2)) u_core (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_pulse), .div_in(div_pulse),
    .up(up), .dn(dn));

  pfd_out u_out (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .pol_hi(pol_hi),
    .aux_en(aux_en), .ref_in(ref_pulse), .div_in(div_pulse),
    .ref_cmp(ref_cmp_o), .div_cmp(div_cmp_o), .main_cmd(main_cmd),
    .aux_cmd(aux_cmd), .lock(lock_o), .mon(mon_o));

  assign up_o       = up;
  assign dn_o       = dn;
  assign pump_src_o = main_cmd.src;
  assign pump_snk_o = main_cmd.snk;
  assign pump_oe_o  = main_cmd.oe;
  assign aux_src_o  = aux_cmd.src;
  assign aux_snk_o  = aux_cmd.snk;
  assign aux_oe_o   = aux_cmd.oe;

  assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pol_hi) |=> $stable(pol_hi) || $past(pol_async) != $past(pol_async, 2));
endmodule

// File: tb/sim_pfd_polarity_top.sv
module sim_pfd_polarity_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, fr, fp, fc, le;
  logic up, dn, rcmp, dcmp, psrc, psnk, poe, asrc, asnk, aoe, lock, mon;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  pfd_polarity_top u0 (
    .clk(clk), .rst_n(rst_n), .ref_pulse(fr), .div_pulse(fp),
    .pol_async(fc), .aux_en_async(le), .up_o(up), .dn_o(dn),
    .ref_cmp_o(rcmp), .div_cmp_o(dcmp), .pump_src_o(psrc),
    .pump_snk_o(psnk), .pump_oe_o(poe), .aux_src_o(asrc),
    .aux_snk_o(asnk), .aux_oe_o(aoe), .lock_o(lock), .mon_o(mon));

  // vector: {fc, le, kind[1:0], gap[3:0]}; kind 0 ref first, 1 div first, 2 together
  localparam logic [7:0] VECS [8] = '{
    {1'b1, 1'b1, 2'd0, 4'd3}, {1'b1, 1'b1, 2'd1, 4'd2},
    {1'b0, 1'b1, 2'd0, 4'd4}, {1'b0, 1'b1, 2'd1, 4'd3},
    {1'b1, 1'b0, 2'd0, 4'd2}, {1'b0, 1'b0, 2'd1, 4'd5},
    {1'b1, 1'b1, 2'd2, 4'd0}, {1'b0, 1'b0, 2'd2, 4'd0}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected {src, snk, oe, div_cmp, ref_cmp} from the polarity rules.
  function automatic logic [4:0] expect_out(input logic pol, input logic u, input logic d);
    if (u && !d) return pol ? 5'b10100 : 5'b01111;  // reference first
    if (d && !u) return pol ? 5'b01111 : 5'b10100;  // divided first
    return 5'b00010;                                 // idle or overlap
  endfunction

  task automatic chk_all(input string req, input logic pol, input logic en,
                         input logic u, input logic d);
    logic [4:0] e;
    e = expect_out(pol, u, d);
    chk({req, " flags"}, {6'd0, up, dn}, {6'd0, u, d});
    chk({req, " pump"}, {3'd0, psrc, psnk, poe, dcmp, rcmp}, {3'd0, e});
    chk("R8 aux", {5'd0, asrc, asnk, aoe}, en ? {5'd0, e[4:2]} : 8'd0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [7:0] v);
    logic pol, en;
    logic [1:0] kind;
    int gap;
    string req;
    pol = v[7]; en = v[6]; kind = v[5:4]; gap = int'(v[3:0]);
    req = pol ? "R3" : "R4";
    fc = pol; le = en;
    repeat (4) step();
    if (kind == 2'd2) begin
      fr = 1; fp = 1; step(); fr = 0; fp = 0;
      chk_all("R2 overlap", pol, en, 1, 1);
      step();
      chk_all("R2 cleared", pol, en, 0, 0);
      chk("R6 lock spike", {7'd0, lock}, 8'd0);
      step();
      chk("R6 lock back", {7'd0, lock}, 8'd1);
    end else begin
      if (kind == 2'd0) fr = 1; else fp = 1;
      step(); fr = 0; fp = 0;
      chk_all({req, " lead"}, pol, en, kind == 2'd0, kind == 2'd1);
      chk("R6 lock lag", {7'd0, lock}, 8'd1);
      repeat (gap - 1) step();
      chk_all({req, " hold"}, pol, en, kind == 2'd0, kind == 2'd1);
      chk("R6 lock low", {7'd0, lock}, 8'd0);
      if (kind == 2'd0) fp = 1; else fr = 1;
      step(); fr = 0; fp = 0;
      chk_all("R5 overlap", pol, en, 1, 1);
      step();
      chk_all("R2 cleared", pol, en, 0, 0);
      step();
      chk("R6 lock high", {7'd0, lock}, 8'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fr = 1; fp = 0; fc = 0; le = 0;
    repeat (3) step();
    // R10 reset state, R9 synchronizers reset high: monitor picks fr
    chk_all("R10 reset", 1, 1, 0, 0);
    chk("R10 lock", {7'd0, lock}, 8'd1);
    chk("R9 reset pol", {7'd0, mon}, 8'd1);
    fr = 0; step();
    rst_n = 1;
    step();
    chk("R9 one edge", {7'd0, mon}, {7'd0, fr});
    fp = 0; fr = 1; #1;
    chk("R9 first edge pol", {7'd0, mon}, 8'd1);
    fr = 0;
    step();
    fp = 1; #1;
    chk("R9 second edge pol", {7'd0, mon}, 8'd1);
    fp = 0;
    repeat (4) step();

    foreach (VECS[i]) run_vec(VECS[i]);

    // R1: held level sets once
    fc = 1; le = 1; repeat (4) step();
    fr = 1; step();
    chk_all("R1 held set", 1, 1, 1, 0);
    fp = 1; step(); fp = 0;
    step();
    repeat (2) step();
    chk_all("R1 held no retrigger", 1, 1, 0, 0);
    fr = 0; step();

    // R9: polarity change while armed takes two edges
    fr = 1; step(); fr = 0;
    chk_all("R9 before", 1, 1, 1, 0);
    fc = 0; step();
    chk_all("R9 old pol", 1, 1, 1, 0);
    step();
    chk_all("R9 new pol", 0, 1, 1, 0);
    fp = 1; step(); fp = 0; step(); step();

    // R7 monitor with low polarity: follows fp
    fr = 1; fp = 0; #1;
    chk("R7 mon fp sel low", {7'd0, mon}, 8'd0);
    step(); fr = 0; fp = 1; #1;
    chk("R7 mon fp sel high", {7'd0, mon}, 8'd1);
    step(); fp = 0; step(); step();
    fc = 1; repeat (4) step();
    fr = 1; fp = 0; #1;
    chk("R7 mon fr sel high", {7'd0, mon}, 8'd1);
    step(); fr = 0; fp = 1; #1;
    chk("R7 mon fr sel low", {7'd0, mon}, 8'd0);
    step(); fp = 0; step(); step();

    // R8 auxiliary enable change while armed; primary unaffected
    fr = 1; step(); fr = 0;
    le = 0; repeat (2) step();
    chk_all("R8 aux off main on", 1, 0, 1, 0);
    le = 1; repeat (2) step();
    chk_all("R8 aux back on", 1, 1, 1, 0);
    fp = 1; step(); fp = 0; step(); step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule